// File: doc/BRIEF.md
# Four-Way Slave FIFO Port

This block lets an external bus master reach one of four internal endpoint FIFOs over a parallel data bus. The external side drives an active-low chip select, a write strobe, a read strobe, an output enable, a packet-end strobe and a 2-bit FIFO selector. Writes become one-cycle push requests toward the selected FIFO, with the captured bus data. Reads become one-cycle pop requests. While output is enabled, the head word of the selected FIFO is driven onto the bus.

A mode input picks between two strobe interpretations. In clocked mode, the write and read strobes act as qualifiers: every interface-clock edge that sees a strobe high produces one transfer. In raw-strobe mode, each strobe passes through a synchronizer and an edge detector, so each pulse produces exactly one transfer, however long the pulse lasts.

A per-FIFO configuration bit selects byte or word width. A byte FIFO only sees the low byte, in both directions. Pushes into a full FIFO and pops from an empty FIFO are dropped, and each leaves a sticky per-FIFO flag. A write that coincides with output enable is reported as bus contention.

Top module: `slaveFifoPort`

## Requirements
- R1: While reset is held and right after it, all push, pop and commit requests are low, every sticky flag is clear, and the bus is not driven (busDataOe = 0, busDataOut = 0).
- R2: Push, pop and commit requests go only to the FIFO numbered by fifoSel (bit n of each request vector for fifoSel = n), and at most one bit of each vector is high in any cycle.
- R3: While csN is high, the write, read, output-enable and packet-end strobes have no effect: no request, no commit, no bus drive and no flag, in either mode.
- R4: In clocked mode (asyncMode = 0), each clock edge that samples wrStb (or rdStb) high with csN low produces one push (or pop) request. The request is visible for the cycle that follows that edge.
- R5: In raw-strobe mode (asyncMode = 1), each rising pulse of wrStb, rdStb or pktEnd with csN low produces exactly one request, whatever the pulse length. The request appears three clock edges after the pulse is first sampled.
- R6: wideCfg bit n set makes FIFO n 16-bit wide; clear makes it 8-bit. For an 8-bit FIFO, pushData bits 15:8 and driven busDataOut bits 15:8 are zero.
- R7: With csN low, oeStb high and wrStb low, the block drives busDataOe = 1 in the same cycle. busDataOut then carries the head word of the selected FIFO (slice n of rdDataFlat, bits 16n+15..16n). Otherwise busDataOut is zero.
- R8: wrStb and oeStb high together with csN low set the sticky contErr output and suppress the bus drive. The write itself still proceeds.
- R9: A rising edge of pktEnd with csN low gives a single-cycle pulse on commitPulse bit fifoSel, even if pktEnd stays high.
- R10: A write to a FIFO whose full bit is set produces no push and sets the sticky ovfFlags bit of that FIFO.
- R11: A read from a FIFO whose empty bit is set produces no pop and sets the sticky udfFlags bit of that FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| asyncMode | input | 1 | 1 = raw strobes with edge detect, 0 = clock-qualified strobes |
| wideCfg | input | 4 | Per-FIFO width, 1 = 16-bit, 0 = 8-bit |
| csN | input | 1 | Active-low chip select |
| wrStb | input | 1 | Write strobe, active high |
| rdStb | input | 1 | Read strobe, active high |
| oeStb | input | 1 | Output enable, active high |
| pktEnd | input | 1 | Packet-end strobe, active high |
| fifoSel | input | 2 | FIFO selector |
| busDataIn | input | 16 | Bus data from the external master |
| busDataOut | output | 16 | Bus data toward the external master |
| busDataOe | output | 1 | Bus drive enable |
| fifoFull | input | 4 | Full status per FIFO |
| fifoEmpty | input | 4 | Empty status per FIFO |
| rdDataFlat | input | 64 | Head word of each FIFO, FIFO n in bits 16n+15..16n |
| pushReq | output | 4 | One-cycle push request per FIFO |
| pushData | output | 16 | Data that goes with a push |
| popReq | output | 4 | One-cycle pop request per FIFO |
| commitPulse | output | 4 | One-cycle packet commit per FIFO |
| ovfFlags | output | 4 | Sticky overflow flag per FIFO |
| udfFlags | output | 4 | Sticky underflow flag per FIFO |
| contErr | output | 1 | Sticky bus-contention flag |

## Verification
A write and an output enable can land in the same cycle. The push must then still occur, while the bus drive is withheld and the contention flag latches. The bench provokes this with one clocked vector that raises both strobes on a word FIFO. It checks that the push carries the full word, that busDataOe and busDataOut stay at zero in that cycle, and that contErr is set and stays set afterwards. Overflow and underflow are exercised the same way: a write or read meets a full or empty status, and the bench judges by counting request pulses and reading the sticky flags.

// File: rtl/slvPkg.sv
package slvPkg;
  parameter int FIFO_SEL_W = 2;
  localparam int FIFO_COUNT = 1 << FIFO_SEL_W;

  typedef struct packed {
    logic                  push;
    logic                  pop;
    logic                  commit;
    logic                  ovf;
    logic                  udf;
    logic                  clash;
    logic                  drive;
    logic [FIFO_SEL_W-1:0] sel;
  } slvEvt_t;
endpackage

// File: rtl/slvCtrl.sv
module slvCtrl
  import slvPkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  asyncMode,
  input  logic                  csN,
  input  logic                  wrStb,
  input  logic                  rdStb,
  input  logic                  oeStb,
  input  logic                  pktEnd,
  input  logic [FIFO_SEL_W-1:0] fifoSel,
  input  logic [FIFO_COUNT-1:0] fifoFull,
  input  logic [FIFO_COUNT-1:0] fifoEmpty,
  output slvEvt_t               evt
);
  localparam int NUM_STB = 3;  // 0 = write, 1 = read, 2 = packet end

  logic [NUM_STB-1:0] gated;
  logic [NUM_STB-1:0] rawEdge;
  logic [NUM_STB-1:0] syncEdge;
  logic [NUM_STB-1:0] event_;
  logic               pkPrev;

  assign gated = {pktEnd, rdStb, wrStb} & {NUM_STB{~csN}};

  for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
    logic [SYNC_DEPTH:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_DEPTH-1:0], gated[s]};
    end
    assign syncEdge[s] = chain[SYNC_DEPTH-1] & ~chain[SYNC_DEPTH];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pkPrev <= 1'b0;
    else       pkPrev <= gated[2];
  end

  // Clocked mode: read/write are level qualifiers, packet end is edge based.
  assign rawEdge = {gated[2] & ~pkPrev, gated[1], gated[0]};
  assign event_  = asyncMode ? syncEdge : rawEdge;

  always_comb begin
    evt        = '0;
    evt.sel    = fifoSel;
    evt.push   = event_[0] & ~fifoFull[fifoSel];
    evt.ovf    = event_[0] &  fifoFull[fifoSel];
    evt.pop    = event_[1] & ~fifoEmpty[fifoSel];
    evt.udf    = event_[1] &  fifoEmpty[fifoSel];
    evt.commit = event_[2];
    evt.clash  = ~csN & wrStb & oeStb;
    evt.drive  = ~csN & oeStb & ~wrStb;
  end

  AST_ASYNC_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (asyncMode && $past(asyncMode) && syncEdge[0]) |=> !syncEdge[0]) else $error("wr edge repeat"); // R5
endmodule

// File: rtl/slvDatapath.sv
module slvDatapath
  import slvPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  slvEvt_t                    evt,
  input  logic [FIFO_COUNT-1:0]      wideCfg,
  input  logic [DATA_W-1:0]          busDataIn,
  input  logic [FIFO_COUNT*DATA_W-1:0] rdDataFlat,
  output logic [DATA_W-1:0]          busDataOut,
  output logic                       busDataOe,
  output logic [FIFO_COUNT-1:0]      pushReq,
  output logic [DATA_W-1:0]          pushData,
  output logic [FIFO_COUNT-1:0]      popReq,
  output logic [FIFO_COUNT-1:0]      commitPulse,
  output logic [FIFO_COUNT-1:0]      ovfFlags,
  output logic [FIFO_COUNT-1:0]      udfFlags,
  output logic                       contErr
);
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] headWord;
  logic [DATA_W-1:0] inMasked;
  logic [DATA_W-1:0] outMasked;
  logic              selWide;

  assign selWide   = wideCfg[evt.sel];
  assign headWord  = rdDataFlat[evt.sel*DATA_W +: DATA_W];
  assign inMasked  = selWide ? busDataIn : {{(DATA_W-BYTE_W){1'b0}}, busDataIn[BYTE_W-1:0]};
  assign outMasked = selWide ? headWord  : {{(DATA_W-BYTE_W){1'b0}}, headWord[BYTE_W-1:0]};

  assign busDataOe  = evt.drive;
  assign busDataOut = evt.drive ? outMasked : '0;

  for (genvar f = 0; f < FIFO_COUNT; f++) begin : g_fifo
    logic hit;
    assign hit = (evt.sel == FIFO_SEL_W'(f));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pushReq[f]     <= 1'b0;
        popReq[f]      <= 1'b0;
        commitPulse[f] <= 1'b0;
        ovfFlags[f]    <= 1'b0;
        udfFlags[f]    <= 1'b0;
      end else begin
        pushReq[f]     <= hit & evt.push;
        popReq[f]      <= hit & evt.pop;
        commitPulse[f] <= hit & evt.commit;
        ovfFlags[f]    <= ovfFlags[f] | (hit & evt.ovf);
        udfFlags[f]    <= udfFlags[f] | (hit & evt.udf);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pushData <= '0;
      contErr  <= 1'b0;
    end else begin
      if (evt.push) pushData <= inMasked;
      contErr <= contErr | evt.clash;
    end
  end

  AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pushReq)) else $error("push not onehot"); // R2
  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(popReq)) else $error("pop not onehot"); // R2
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (commitPulse != '0) |=> (commitPulse == '0)) else $error("commit too long"); // R9
  AST_CLASH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(contErr) |-> contErr) else $error("contErr cleared"); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfFlags & $past(ovfFlags)) == $past(ovfFlags))) else $error("ovf cleared"); // R10
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((udfFlags & $past(udfFlags)) == $past(udfFlags))) else $error("udf cleared"); // R11
endmodule

// File: rtl/slaveFifoPort.sv
module slaveFifoPort
  import slvPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         asyncMode,
  input  logic [FIFO_COUNT-1:0]        wideCfg,
  input  logic                         csN,
  input  logic                         wrStb,
  input  logic                         rdStb,
  input  logic                         oeStb,
  input  logic                         pktEnd,
  input  logic [FIFO_SEL_W-1:0]        fifoSel,
  input  logic [DATA_W-1:0]            busDataIn,
  output logic [DATA_W-1:0]            busDataOut,
  output logic                         busDataOe,
  input  logic [FIFO_COUNT-1:0]        fifoFull,
  input  logic [FIFO_COUNT-1:0]        fifoEmpty,
  input  logic [FIFO_COUNT*DATA_W-1:0] rdDataFlat,
  output logic [FIFO_COUNT-1:0]        pushReq,
  output logic [DATA_W-1:0]            pushData,
  output logic [FIFO_COUNT-1:0]        popReq,
  output logic [FIFO_COUNT-1:0]        commitPulse,
  output logic [FIFO_COUNT-1:0]        ovfFlags,
  output logic [FIFO_COUNT-1:0]        udfFlags,
  output logic                         contErr
);
  slvEvt_t evt;

  slvCtrl #(.SYNC_DEPTH(SYNC_DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .asyncMode(asyncMode), .csN(csN),
    .wrStb(wrStb), .rdStb(rdStb), .oeStb(oeStb), .pktEnd(pktEnd),
    .fifoSel(fifoSel), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .evt(evt)
  );

  slvDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .evt(evt), .wideCfg(wideCfg),
    .busDataIn(busDataIn), .rdDataFlat(rdDataFlat),
    .busDataOut(busDataOut), .busDataOe(busDataOe),
    .pushReq(pushReq), .pushData(pushData), .popReq(popReq),
    .commitPulse(commitPulse), .ovfFlags(ovfFlags), .udfFlags(udfFlags),
    .contErr(contErr)
  );

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ((pushReq & $past(fifoFull)) == '0)) else $error("push into full"); // R10
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ((popReq & $past(fifoEmpty)) == '0)) else $error("pop from empty"); // R11
endmodule

// File: tb/test_slaveFifoPort.sv
`timescale 1ns/1ps
module test_slaveFifoPort;
  logic        clk = 1'b0;
  logic        rstN;
  logic        asyncMode;
  logic [3:0]  wideCfg;
  logic        csN, wrStb, rdStb, oeStb, pktEnd;
  logic [1:0]  fifoSel;
  logic [15:0] busDataIn, busDataOut, pushData;
  logic        busDataOe, contErr;
  logic [3:0]  fifoFull, fifoEmpty, pushReq, popReq, commitPulse, ovfFlags, udfFlags;
  logic [63:0] rdDataFlat;

  int nRun = 0, nFail = 0;
  int pushTot = 0, popTot = 0, comTot = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slaveFifoPort i_slaveFifoPort (
    .clk(clk), .rstN(rstN), .asyncMode(asyncMode), .wideCfg(wideCfg),
    .csN(csN), .wrStb(wrStb), .rdStb(rdStb), .oeStb(oeStb), .pktEnd(pktEnd),
    .fifoSel(fifoSel), .busDataIn(busDataIn), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .rdDataFlat(rdDataFlat), .pushReq(pushReq), .pushData(pushData),
    .popReq(popReq), .commitPulse(commitPulse), .ovfFlags(ovfFlags),
    .udfFlags(udfFlags), .contErr(contErr)
  );

  always @(negedge clk) if (rstN) begin
    pushTot += $countones(pushReq);
    popTot  += $countones(popReq);
    comTot  += $countones(commitPulse);
  end

  typedef struct packed {
    logic cs_n, wr, rd, oe, pk;
    logic [1:0]  sel;
    logic [15:0] din;
    logic [3:0]  ePush, ePop, eCom;
    logic [15:0] ePushData;
    logic        eOe;
    logic [15:0] eDout;
  } vec_t;

  localparam int NVEC = 8;
  // heads: f0 A1B2, f1 C3D4, f2 E5F6, f3 1728; wide = f1, f3
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,16'hBEEF,4'b0001,4'b0000,4'b0000,16'h00EF,1'b0,16'h0000}, // R2 R4 R6 byte push
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd1,16'hBEEF,4'b0010,4'b0000,4'b0000,16'hBEEF,1'b0,16'h0000}, // R4 R6 word push
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'd2,16'h0000,4'b0000,4'b0100,4'b0000,16'h0000,1'b1,16'h00F6}, // R6 R7 byte read
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'd3,16'h0000,4'b0000,4'b1000,4'b0000,16'h0000,1'b1,16'h1728}, // R4 R7 word read
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd0,16'h5555,4'b0000,4'b0000,4'b0000,16'h0000,1'b0,16'h0000}, // R3 deselected
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,16'h0000,4'b0000,4'b0000,4'b0100,16'h0000,1'b0,16'h0000}, // R9 commit
    '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,16'h0000,4'b0000,4'b0000,4'b0000,16'h0000,1'b1,16'hC3D4}, // R7 oe only
    '{1'b0,1'b1,1'b0,1'b1,1'b0,2'd3,16'h1234,4'b1000,4'b0000,4'b0000,16'h1234,1'b0,16'h0000}  // R8 clash
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  task automatic idle();
    csN = 1'b0; wrStb = 0; rdStb = 0; oeStb = 0; pktEnd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int p0, c0;
    rstN = 0; asyncMode = 0; wideCfg = 4'b1010; fifoFull = 0; fifoEmpty = 0;
    fifoSel = 0; busDataIn = 0;
    rdDataFlat = {16'h1728, 16'hE5F6, 16'hC3D4, 16'hA1B2};
    idle();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reqs in reset", {pushReq, popReq, commitPulse}, 0);
    chk("R1 flags in reset", {ovfFlags, udfFlags, 3'b0, contErr}, 0);
    chk("R1 bus idle", {15'b0, busDataOe, busDataOut}, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 after reset", {pushReq, popReq, commitPulse, contErr}, 0);

    // table, clocked mode
    for (int v = 0; v < NVEC; v++) begin
      csN = VECS[v].cs_n; wrStb = VECS[v].wr; rdStb = VECS[v].rd;
      oeStb = VECS[v].oe; pktEnd = VECS[v].pk; fifoSel = VECS[v].sel;
      busDataIn = VECS[v].din;
      #1;
      chk($sformatf("R7 vec%0d oe", v), busDataOe, VECS[v].eOe);
      chk($sformatf("R7 vec%0d dout", v), busDataOut, VECS[v].eDout);
      @(negedge clk);
      chk($sformatf("R2 vec%0d push", v), pushReq, VECS[v].ePush);
      chk($sformatf("R2 vec%0d pop", v), popReq, VECS[v].ePop);
      chk($sformatf("R9 vec%0d commit", v), commitPulse, VECS[v].eCom);
      if (VECS[v].ePush != 0)
        chk($sformatf("R6 vec%0d pushData", v), pushData, VECS[v].ePushData);
      idle();
      @(negedge clk);
    end
    chk("R8 contErr set", contErr, 1);
    repeat (2) @(negedge clk);
    chk("R8 contErr sticky", contErr, 1);
    chk("R3 no flags from deselected", {ovfFlags, udfFlags}, 0);

    // R4: three consecutive clocked writes
    p0 = pushTot;
    fifoSel = 2; wrStb = 1; busDataIn = 16'hAB12;
    repeat (3) @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    chk("R4 three pushes", pushTot - p0, 3);

    // R9: held packet end gives one commit
    c0 = comTot;
    fifoSel = 1; pktEnd = 1;
    repeat (4) @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    chk("R9 held pktEnd single commit", comTot - c0, 1);

    // R10 overflow
    p0 = pushTot;
    fifoFull = 4'b0100; fifoSel = 2; wrStb = 1;
    @(negedge clk);
    idle(); fifoFull = 0;
    repeat (2) @(negedge clk);
    chk("R10 no push when full", pushTot - p0, 0);
    chk("R10 ovf flag", ovfFlags, 4'b0100);

    // R11 underflow
    p0 = popTot;
    fifoEmpty = 4'b0001; fifoSel = 0; rdStb = 1;
    @(negedge clk);
    idle(); fifoEmpty = 0;
    repeat (2) @(negedge clk);
    chk("R11 no pop when empty", popTot - p0, 0);
    chk("R11 udf flag", udfFlags, 4'b0001);

    // R5 raw-strobe mode
    asyncMode = 1;
    repeat (4) @(negedge clk);
    p0 = pushTot;
    fifoSel = 0; busDataIn = 16'h3377; wrStb = 1;
    repeat (5) @(negedge clk);
    wrStb = 0;
    repeat (6) @(negedge clk);
    chk("R5 long pulse one push", pushTot - p0, 1);
    chk("R5 R6 async byte data", pushData, 16'h0077);

    // R5 timing: request three edges after first sample
    p0 = pushTot;
    fifoSel = 3; busDataIn = 16'h9abc; wrStb = 1;
    repeat (2) @(negedge clk);
    wrStb = 0;
    chk("R5 no push before third edge", pushReq, 4'b0000);
    @(negedge clk);
    chk("R5 push at third edge", pushReq, 4'b1000);
    repeat (4) @(negedge clk);
    chk("R5 short pulse one push", pushTot - p0, 1);

    // R5 async read and commit
    p0 = popTot; c0 = comTot;
    fifoSel = 1; rdStb = 1; pktEnd = 1;
    repeat (4) @(negedge clk);
    rdStb = 0; pktEnd = 0;
    repeat (5) @(negedge clk);
    chk("R5 async pop once", popTot - p0, 1);
    chk("R5 async commit once", comTot - c0, 1);

    // R3 deselected in raw-strobe mode
    p0 = pushTot;
    csN = 1; wrStb = 1;
    repeat (4) @(negedge clk);
    wrStb = 0;
    repeat (5) @(negedge clk);
    chk("R3 async deselected no push", pushTot - p0, 0);
    idle();

    finishRun();
  end
endmodule